// File: doc/BRIEF.md
# Word Serializer with Phase-Placed Forwarded Clock

This block shifts 8-bit parallel words out as a serial bit stream, most significant bit first. Alongside the data it produces a forwarded clock whose frequency and edge placement are programmable relative to that stream, so a receiver can be given an edge-aligned, centre-aligned or double-data-rate clock. Everything runs from a single oversampling clock that makes eight ticks per serial bit, so one tick equals 45 degrees of a bit period and 360 degrees equals one full bit.

A word is presented on `word_in` with a one-cycle `load_strobe`. From idle, the word starts on the very next cycle. While a word is in flight, a strobed word waits for the next word boundary. With no new word, the last one repeats. The phase and frequency settings are sampled when a word starts, so changes made mid-word only apply from the next word.

Top module: `fwdclk_serializer`

## Requirements
- R1: After a synchronous active-low reset, and until the first strobe, `ser_out` and `fwd_clk` are both 0. A reset in mid-stream returns both to 0 on the next cycle.
- R2: Bits leave MSB first. Each bit is held on `ser_out` for exactly 8 clock cycles, so a word lasts 64 cycles.
- R3: A strobe sampled while idle puts bit 7 of that word on `ser_out` in the cycle after the strobe edge. That cycle is tick 0 of the word.
- R4: A strobe sampled while a word is in flight holds that word until the next word boundary, where it starts. If several strobes arrive before the boundary, the last one wins. A strobe sampled on the boundary edge itself (tick 63) starts its word immediately at tick 0.
- R5: If no word was strobed during a word, the same word is sent again.
- R6: `div_in` selects the forwarded clock period: code 0 gives 8 ticks (factor 1), code 1 gives 16 ticks (factor 2, data changes on both clock edges), code 2 gives 32 ticks, and code 3 gives 64 ticks (one period per word). The duty cycle is 50%.
- R7: `phase_in` counts 45-degree steps from 0 to 63. The forwarded clock rises on word tick `phase_in mod period`. Step 0 rises at the start of the MSB, step 4 in the middle of the MSB, and step 12 in the middle of the bit after the MSB.
- R8: `phase_in` and `div_in` are captured only when a word starts, either from idle or at a boundary. Changing them mid-word has no effect until the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 8 ticks per serial bit |
| rst_n | input | 1 | Synchronous reset, active low |
| load_strobe | input | 1 | One-cycle request to send `word_in` |
| word_in | input | 8 | Parallel word to serialize |
| phase_in | input | 6 | Forwarded clock edge position in 45-degree steps |
| div_in | input | 2 | Forwarded clock division code (period = 8 << code ticks) |
| ser_out | output | 1 | Serial data, MSB first |
| fwd_clk | output | 1 | Forwarded clock |

## Verification
The first word's MSB and the matching clock level are due one cycle after a strobe from idle. The bench therefore drives the strobe at a falling edge and checks the outputs at the next falling edge. From then on, both outputs are compared at every falling edge against a tick-by-tick model that advances one tick per rising edge. A strobe during a word first becomes visible at tick 0 after the boundary, 64 cycles at most after the strobe. Settings changed mid-word must show no effect until that same tick 0. Rise positions and high counts are measured over a whole second word, so that an edge at tick 0 is also seen.

// File: rtl/fs_pkg.sv
// fs_pkg: shared types for the forwarded-clock serializer.
// Assumes: division codes select power-of-two factors 1, 2, 4 and 8.
package fs_pkg;
    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2,
        DIV_BY8 = 2'd3
    } div_code_e;
endpackage

// File: rtl/fs_timebase.sv
// fs_timebase: word tick counter. It counts 0 .. 2**POS_W-1 through one word
// and flags the start from idle and each word boundary.
// Assumes: word length in ticks (WORD_W*OVS) is a power of two.
module fs_timebase #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_strobe,
    output logic             running,
    output logic [POS_W-1:0] pos,
    output logic             start,
    output logic             boundary
);
    logic             run_q;
    logic [POS_W-1:0] pos_q;

    // Start from idle on a strobe; boundary on the last tick of a word.
    assign start    = !run_q && load_strobe;
    assign boundary = run_q && (pos_q == '1);
    assign running  = run_q;
    assign pos      = pos_q;

    // Advance the tick position once per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pos_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            pos_q <= '0;
        end else if (run_q) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // R3: a start from idle lands on tick 0 of a running word.
    a_r3_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && pos == '0));

    // R2: once running, the position advances by exactly one per cycle.
    a_r2_pos_advance: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (running && pos == POS_W'($past(pos) + 1'b1)));
endmodule

// File: rtl/fs_datapath.sv
// fs_datapath: holds the current word and one pending word, and selects the
// serial bit from the tick position, MSB first.
// Assumes: the timebase supplies start/boundary pulses and the tick position.
module fs_datapath #(
    parameter int WORD_W = 8,
    parameter int POS_W  = 6,
    parameter int TICK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_strobe,
    input  logic [WORD_W-1:0] word_in,
    input  logic              running,
    input  logic [POS_W-1:0]  pos,
    input  logic              start,
    input  logic              boundary,
    output logic              ser_out
);
    localparam int BIT_W = POS_W - TICK_W;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] pend_q;
    logic              pend_v;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIT_W-1:0]  msb_sel;

    // Choose the word bit: bit index 0 of the word time maps to the MSB.
    assign bit_idx = pos[POS_W-1:TICK_W];
    assign msb_sel = BIT_W'(WORD_W - 1) - bit_idx;
    assign ser_out = running && word_q[msb_sel];

    // Take a word on start, swap in the pending or fresh word at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (start) begin
            word_q <= word_in;
            pend_v <= 1'b0;
        end else if (boundary) begin
            if (load_strobe)
                word_q <= word_in;
            else if (pend_v)
                word_q <= pend_q;
            pend_v <= 1'b0;
        end else if (running && load_strobe) begin
            pend_q <= word_in;
            pend_v <= 1'b1;
        end
    end

    // R1: no data leaves while idle.
    a_r1_idle_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !ser_out);

    // R2: the serial bit only moves on the last tick of a bit.
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pos[TICK_W-1:0] != '1) |=> $stable(ser_out));

    // R5: with nothing waiting, the word repeats across a boundary.
    a_r5_word_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !load_strobe && !pend_v) |=> (word_q == $past(word_q)));

    // R4: a waiting word is the one that starts at the boundary.
    a_r4_pending_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !load_strobe && pend_v) |=> (word_q == $past(pend_q)));
endmodule

// File: rtl/fs_clkgen.sv
// fs_clkgen: forwarded clock. It captures phase and division at each word
// start and drives a 50% duty clock that rises on tick (phase mod period).
// Assumes: the longest period (OVS*8) divides the word length in ticks.
module fs_clkgen
    import fs_pkg::*;
#(
    parameter int OVS     = 8,
    parameter int POS_W   = 6,
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic [POS_W-1:0]   pos,
    input  logic               start,
    input  logic               boundary,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic [1:0]         div_in,
    output logic               fwd_clk
);
    localparam int PER_W = POS_W + 1;

    logic [PHASE_W-1:0] phase_q;
    div_code_e          div_q;
    logic [PER_W-1:0]   per;
    logic [PER_W-1:0]   mask;
    logic [PER_W-1:0]   edge_tick;
    logic [PER_W-1:0]   diff;

    // Capture the clock settings only when a word begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            div_q   <= DIV_BY1;
        end else if (start || boundary) begin
            phase_q <= phase_in;
            div_q   <= div_code_e'(div_in);
        end
    end

    // Period, edge tick, and high for the first half-period after the edge.
    always_comb begin
        per       = PER_W'(OVS) << div_q;
        mask      = per - 1'b1;
        edge_tick = PER_W'(phase_q) & mask;
        diff      = ({1'b0, pos} - edge_tick) & mask;
        fwd_clk   = running && (diff < (per >> 1));
    end

    // R1: the forwarded clock stays low while idle.
    a_r1_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !fwd_clk);

    // R7: inside a word, every rising edge sits on the programmed tick.
    a_r7_rise_on_edge_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && pos != '0 && $rose(fwd_clk))
            |-> ((({1'b0, pos} - PER_W'(phase_q)) & mask) == '0));

    // R8: settings hold steady except across a word boundary.
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !boundary) |=> ($stable(phase_q) && $stable(div_q)));
endmodule

// File: rtl/fwdclk_serializer.sv
// fwdclk_serializer: top. It serializes words MSB first and drives a forwarded
// clock of programmable phase (45-degree steps) and division factor.
// Assumes: one oversampling clock with OVS ticks per serial bit.
module fwdclk_serializer #(
    parameter int WORD_W  = 8,
    parameter int OVS     = 8,
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_strobe,
    input  logic [WORD_W-1:0]  word_in,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic [1:0]         div_in,
    output logic               ser_out,
    output logic               fwd_clk
);
    localparam int TICK_W = $clog2(OVS);
    localparam int POS_W  = $clog2(WORD_W * OVS);

    logic             running;
    logic [POS_W-1:0] pos;
    logic             start;
    logic             boundary;

    fs_timebase #(.POS_W(POS_W)) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_strobe (load_strobe),
        .running     (running),
        .pos         (pos),
        .start       (start),
        .boundary    (boundary)
    );

    fs_datapath #(.WORD_W(WORD_W), .POS_W(POS_W), .TICK_W(TICK_W)) u_datapath (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_strobe (load_strobe),
        .word_in     (word_in),
        .running     (running),
        .pos         (pos),
        .start       (start),
        .boundary    (boundary),
        .ser_out     (ser_out)
    );

    fs_clkgen #(.OVS(OVS), .POS_W(POS_W), .PHASE_W(PHASE_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .pos      (pos),
        .start    (start),
        .boundary (boundary),
        .phase_in (phase_in),
        .div_in   (div_in),
        .fwd_clk  (fwd_clk)
    );
endmodule

// File: tb/tb_fwdclk_serializer.sv
`timescale 1ns/1ps
module tb_fwdclk_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_strobe = 1'b0;
    logic [7:0] word_in = '0;
    logic [5:0] phase_in = '0;
    logic [1:0] div_in = '0;
    logic       ser_out;
    logic       fwd_clk;

    int checks = 0;
    int failures = 0;

    // model state
    bit         m_run = 0;
    bit         m_pv = 0;
    logic [7:0] m_w = '0;
    logic [7:0] m_pend = '0;
    int         m_pos = 0;
    int         m_ph = 0;
    int         m_d = 0;

    // vector: {word, phase steps, div code, expected rise tick in word}
    localparam logic [21:0] VEC [8] = '{
        {8'hA5, 6'd0,  2'd3, 6'd0},
        {8'h3C, 6'd4,  2'd3, 6'd4},
        {8'h96, 6'd12, 2'd1, 6'd12},
        {8'hF0, 6'd12, 2'd0, 6'd4},
        {8'h81, 6'd63, 2'd2, 6'd31},
        {8'h5A, 6'd36, 2'd1, 6'd4},
        {8'h00, 6'd2,  2'd3, 6'd2},
        {8'hFF, 6'd40, 2'd3, 6'd40}
    };

    fwdclk_serializer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_strobe (load_strobe),
        .word_in     (word_in),
        .phase_in    (phase_in),
        .div_in      (div_in),
        .ser_out     (ser_out),
        .fwd_clk     (fwd_clk)
    );

    always #2.5 clk = ~clk;

    task automatic check_val(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Wait for one rising edge (sampled at the next falling edge), update model, compare.
    task automatic adv(input string req);
        int per;
        int e;
        bit exp_ser;
        bit exp_clk;
        @(negedge clk);
        if (!m_run) begin
            if (load_strobe) begin
                m_run = 1; m_pos = 0; m_w = word_in; m_pv = 0;
                m_ph = int'(phase_in); m_d = int'(div_in);
            end
        end else if (m_pos == 63) begin
            m_w = load_strobe ? word_in : (m_pv ? m_pend : m_w);
            m_pv = 0; m_ph = int'(phase_in); m_d = int'(div_in); m_pos = 0;
        end else begin
            if (load_strobe) begin m_pend = word_in; m_pv = 1; end
            m_pos++;
        end
        per = 8 << m_d;
        e = m_ph % per;
        exp_ser = m_run && m_w[7 - m_pos / 8];
        exp_clk = m_run && (((m_pos - e + 64) % per) < per / 2);
        checks++;
        if (ser_out !== exp_ser || fwd_clk !== exp_clk) begin
            failures++;
            $display("FAIL %s: tick=%0d ser actual=%0b expected=%0b clk actual=%0b expected=%0b",
                     req, m_pos, ser_out, exp_ser, fwd_clk, exp_clk);
        end
    endtask

    task automatic do_reset();
        load_strobe = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_run = 0; m_pv = 0; m_pos = 0;
    endtask

    task automatic load(input logic [7:0] w, input logic [5:0] ph, input logic [1:0] d, input string req);
        word_in = w; phase_in = ph; div_in = d; load_strobe = 1'b1;
        adv(req);
        load_strobe = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1: reset state and quiet idle
        do_reset();
        check_val("R1 ser after reset", int'(ser_out), 0);
        check_val("R1 clk after reset", int'(fwd_clk), 0);
        for (int i = 0; i < 20; i++) adv("R1");

        // Table of vectors: first word from idle, then measure the repeated second word
        for (int v = 0; v < 8; v++) begin
            int rise;
            int rises;
            int highs;
            logic prev;
            do_reset();
            load(VEC[v][21:14], VEC[v][13:8], VEC[v][7:6], "R3");
            for (int t = 1; t < 64; t++) adv("R2");
            rise = -1; rises = 0; highs = 0; prev = fwd_clk;
            for (int t = 0; t < 64; t++) begin
                adv("R5");
                if (!prev && fwd_clk) begin
                    rises++;
                    if (rise < 0) rise = t;
                end
                if (fwd_clk) highs++;
                prev = fwd_clk;
            end
            check_val("R7 first rise tick", rise, int'(VEC[v][5:0]));
            check_val("R6 rises per word", rises, 8 >> VEC[v][7:6]);
            check_val("R6 high ticks per word", highs, 32);
        end

        // R4: strobes mid-word wait for the boundary; the last one wins
        do_reset();
        load(8'hC3, 6'd0, 2'd3, "R3");
        for (int t = 1; t < 20; t++) adv("R4");
        word_in = 8'h18; load_strobe = 1'b1; adv("R4"); load_strobe = 1'b0;
        for (int t = 0; t < 10; t++) adv("R4");
        word_in = 8'h7E; load_strobe = 1'b1; adv("R4"); load_strobe = 1'b0;
        while (m_pos != 63) adv("R4");
        for (int t = 0; t < 64; t++) adv("R4");
        // R4: strobe on the boundary edge starts immediately
        while (m_pos != 63) adv("R4");
        word_in = 8'h2D; load_strobe = 1'b1; adv("R4"); load_strobe = 1'b0;
        for (int t = 0; t < 64; t++) adv("R4");

        // R8: settings changed mid-word apply only from the next word
        do_reset();
        load(8'h69, 6'd0, 2'd3, "R3");
        for (int t = 1; t < 10; t++) adv("R8");
        phase_in = 6'd4; div_in = 2'd0;
        while (m_pos != 63) adv("R8");
        for (int t = 0; t < 64; t++) adv("R8");

        // R1: reset in mid-stream silences both outputs
        do_reset();
        load(8'hFF, 6'd0, 2'd3, "R3");
        for (int t = 0; t < 5; t++) adv("R1");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_run = 0; m_pv = 0; m_pos = 0;
        check_val("R1 ser after mid reset", int'(ser_out), 0);
        check_val("R1 clk after mid reset", int'(fwd_clk), 0);
        for (int t = 0; t < 10; t++) adv("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule